// File: doc/BRIEF.md
# DMA Channel Event Interrupt Controller

This block gathers the per-channel notifications of a small DMA controller into one interrupt line for the CPU. The transfer engine reports five kinds of event as single-cycle pulses: a synchronization event that was lost, half of a frame moved, a frame finished, the last frame started, and the whole block finished. A sixth event, the stall time-out, is produced inside the block. Each of four memory ports has its own watchdog counter that runs while an access request waits for its grant.

Every event sets a sticky bit in a status register, whether or not it is enabled. A 6-bit enable mask decides which events may interrupt. The CPU receives a one-cycle request pulse and never has to acknowledge it. Software reads the status register to find out which events fired, and that read clears it. Register access uses a plain synchronous strobe bus with a one-bit address: address 0 holds the enable mask and address 1 holds the status.

Top module: `dma_chan_irq`

## Requirements
- R1: Event bit positions in the enable and status registers are: bit 0 lost sync, bit 1 half frame, bit 2 frame done, bit 3 last frame, bit 4 block done, bit 5 stall time-out. A status bit is set on the clock after its event, whatever the enable mask holds.
- R2: An event whose enable bit is 1 raises `irq_o` for the cycle that follows the clock edge on which the event was sampled.
- R3: An event whose enable bit is 0 never raises `irq_o`.
- R4: Status bits stay set until a read of address 1 (`bus_rd_i`=1, `bus_addr_i`=1). That read returns the status and clears it on the same edge.
- R5: An event sampled on the same edge as a status read stays set in the status register afterwards.
- R6: Each port counts the clock edges on which its request is high and its grant is low. When the count reaches 255, a stall time-out event (bit 5) is raised.
- R7: A port's count returns to zero when the grant is high or the request is low. The count saturates at 255, so one stall gives exactly one time-out event. Time-outs on several ports in the same cycle make one event.
- R8: A write to address 0 loads the enable mask and a read of address 0 returns it. A write that enables a bit already set in the status register raises `irq_o` for one cycle.
- R9: After reset the enable mask and the status register are 0 and `irq_o` is low.
- R10: `irq_o` is one cycle wide for each triggering edge. Events on consecutive edges give consecutive pulses, and no response from the CPU is needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_sync_lost_i | input | 1 | Pulse: a synchronization event was dropped |
| ev_half_i | input | 1 | Pulse: half a frame transferred |
| ev_frame_i | input | 1 | Pulse: frame transfer done |
| ev_last_i | input | 1 | Pulse: last frame started |
| ev_block_i | input | 1 | Pulse: block transfer done |
| port_req_i | input | 4 | Access request per memory port |
| port_gnt_i | input | 4 | Access grant per memory port |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 1 | 0: enable mask, 1: status |
| bus_wdata_i | input | 6 | Write data |
| bus_rdata_o | output | 6 | Read data for the addressed register |
| irq_o | output | 1 | One-cycle channel interrupt request |

## Verification
The interrupt path is driven with single enabled events, single masked events, two events on the same edge, and the same event on back-to-back edges. Together these separate the mask gating, the merging of simultaneous events and the per-edge pulse width. The status path is tested with a read that lands on the same edge as a new event, and with an enable write that unmasks an event already pending. The stall counters are run with a request held past 255 cycles, a grant arriving partway through, a withdrawal at 254 cycles, and two ports stalling together. These cases separate the saturation, the clearing and the merging of the time-out.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int NUM_EVT     = 6;
  localparam int NUM_PORTS   = 4;
  localparam int STALL_LIMIT = 255;
  localparam int CNT_W       = $clog2(STALL_LIMIT + 1);

  localparam int EV_SYNC_LOST = 0;
  localparam int EV_HALF      = 1;
  localparam int EV_FRAME     = 2;
  localparam int EV_LAST      = 3;
  localparam int EV_BLOCK     = 4;
  localparam int EV_STALL     = 5;

  localparam logic ADDR_MASK   = 1'b0;
  localparam logic ADDR_STATUS = 1'b1;

  typedef logic [NUM_EVT-1:0] evt_vec_t;
endpackage

// File: rtl/dma_irq_rst_sync.sv
module dma_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_core_n = sync_q[STAGES-1];
endmodule

// File: rtl/dma_irq_stall_timer.sv
module dma_irq_stall_timer #(
  parameter int LIMIT = 255,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic gnt_i,
  output logic tmo_o
);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tmo_q, tmo_d;
  logic          waiting;

  always_comb begin
    waiting = req_i && !gnt_i;
    if (!waiting)          cnt_d = '0;
    else if (cnt_q == LIM) cnt_d = cnt_q;
    else                   cnt_d = cnt_q + 1'b1;
    tmo_d = (cnt_q != LIM) && (cnt_d == LIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tmo_q <= tmo_d;
    end
  end

  assign tmo_o = tmo_q;
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         clr_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] status_q, status_d;

  always_comb begin
    status_d = status_q;
    if (clr_i) status_d = '0;
    status_d = status_d | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status_o = status_q;
endmodule

// File: rtl/dma_irq_pulse.sv
module dma_irq_pulse #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] status_i,
  input  logic         mask_wr_i,
  input  logic [N-1:0] mask_wdata_i,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] mask_q, mask_d;
  logic         irq_q, irq_d;
  logic         hit_new, hit_unmask;

  always_comb begin
    mask_d     = mask_wr_i ? mask_wdata_i : mask_q;
    hit_new    = |(evt_i & mask_q);
    hit_unmask = mask_wr_i && |(status_i & mask_wdata_i & ~mask_q);
    irq_d      = hit_new || hit_unmask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      irq_q  <= irq_d;
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/dma_chan_irq.sv
module dma_chan_irq
  import dma_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev_sync_lost_i,
  input  logic                 ev_half_i,
  input  logic                 ev_frame_i,
  input  logic                 ev_last_i,
  input  logic                 ev_block_i,
  input  logic [NUM_PORTS-1:0] port_req_i,
  input  logic [NUM_PORTS-1:0] port_gnt_i,
  input  logic                 bus_wr_i,
  input  logic                 bus_rd_i,
  input  logic                 bus_addr_i,
  input  logic [NUM_EVT-1:0]   bus_wdata_i,
  output logic [NUM_EVT-1:0]   bus_rdata_o,
  output logic                 irq_o
);
  logic                 rst_core_n;
  logic [NUM_PORTS-1:0] tmo_vec;
  evt_vec_t             evt_vec;
  evt_vec_t             status_q;
  evt_vec_t             mask_q;
  logic                 rd_clr;
  logic                 mask_wr;

  dma_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    dma_irq_stall_timer #(.LIMIT(STALL_LIMIT), .CW(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_core_n),
      .req_i (port_req_i[p]),
      .gnt_i (port_gnt_i[p]),
      .tmo_o (tmo_vec[p])
    );
  end

  always_comb begin
    evt_vec               = '0;
    evt_vec[EV_SYNC_LOST] = ev_sync_lost_i;
    evt_vec[EV_HALF]      = ev_half_i;
    evt_vec[EV_FRAME]     = ev_frame_i;
    evt_vec[EV_LAST]      = ev_last_i;
    evt_vec[EV_BLOCK]     = ev_block_i;
    evt_vec[EV_STALL]     = |tmo_vec;
    rd_clr                = bus_rd_i && (bus_addr_i == ADDR_STATUS);
    mask_wr               = bus_wr_i && (bus_addr_i == ADDR_MASK);
    bus_rdata_o           = (bus_addr_i == ADDR_STATUS) ? status_q : mask_q;
  end

  dma_irq_status #(.N(NUM_EVT)) u_status (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .evt_i    (evt_vec),
    .clr_i    (rd_clr),
    .status_o (status_q)
  );

  dma_irq_pulse #(.N(NUM_EVT)) u_pulse (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .evt_i        (evt_vec),
    .status_i     (status_q),
    .mask_wr_i    (mask_wr),
    .mask_wdata_i (bus_wdata_i),
    .mask_o       (mask_q),
    .irq_o        (irq_o)
  );
endmodule

// File: rtl/dma_chan_irq_chk.sv
module dma_chan_irq_chk
  import dma_irq_pkg::*;
(
  input logic                 clk,
  input logic                 rst_core_n,
  input logic [NUM_EVT-1:0]   evt_vec,
  input logic [NUM_EVT-1:0]   mask_q,
  input logic [NUM_EVT-1:0]   status_q,
  input logic [NUM_PORTS-1:0] tmo_vec,
  input logic                 rd_clr,
  input logic                 mask_wr,
  input logic                 irq_o
);
  a_r1_event_recorded: assert property (@(posedge clk) disable iff (!rst_core_n)
    (|evt_vec) |=> ((status_q & $past(evt_vec)) == $past(evt_vec)));

  a_r2_enabled_raises: assert property (@(posedge clk) disable iff (!rst_core_n)
    (|(evt_vec & mask_q)) |=> irq_o);

  a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((evt_vec & mask_q) == '0 && !mask_wr) |=> !irq_o);

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_core_n)
    !rd_clr |=> ((status_q & $past(status_q)) == $past(status_q)));

  a_r5_read_keeps_new: assert property (@(posedge clk) disable iff (!rst_core_n)
    rd_clr |=> (status_q == $past(evt_vec)));

  a_r7_single_timeout: assert property (@(posedge clk) disable iff (!rst_core_n)
    (|tmo_vec) |=> ((tmo_vec & $past(tmo_vec)) == '0));
endmodule

bind dma_chan_irq dma_chan_irq_chk u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .evt_vec    (evt_vec),
  .mask_q     (mask_q),
  .status_q   (status_q),
  .tmo_vec    (tmo_vec),
  .rd_clr     (rd_clr),
  .mask_wr    (mask_wr),
  .irq_o      (irq_o)
);

// File: tb/dma_chan_irq_bench.sv
module dma_chan_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ev_sync_lost, ev_half, ev_frame, ev_last, ev_block;
  logic [3:0] port_req, port_gnt;
  logic       bus_wr, bus_rd, bus_addr;
  logic [5:0] bus_wdata, bus_rdata;
  logic       irq;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    mon_on = 1'b0;
  bit    finished = 1'b0;
  int    exp_cyc[$];
  string exp_tag[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dma_chan_irq u_dma_chan_irq (
    .clk(clk), .rst_n(rst_n),
    .ev_sync_lost_i(ev_sync_lost), .ev_half_i(ev_half), .ev_frame_i(ev_frame),
    .ev_last_i(ev_last), .ev_block_i(ev_block),
    .port_req_i(port_req), .port_gnt_i(port_gnt),
    .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // scoreboard monitor: compares irq against queued expected pulse cycles
  always @(negedge clk) begin
    if (mon_on) begin
      if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
        check(irq == 1'b1, exp_tag[0], int'(irq), 1);
        void'(exp_cyc.pop_front());
        void'(exp_tag.pop_front());
      end else if (irq) begin
        check(1'b0, "R3/R10 unexpected irq", 1, 0);
      end
    end
  end

  task automatic expect_irq(input int at, input string tag);
    exp_cyc.push_back(at);
    exp_tag.push_back(tag);
  endtask

  // mask bits: 0 sync lost, 1 half, 2 frame, 3 last, 4 block
  task automatic pulse(input logic [4:0] m, input bit want, input string tag);
    {ev_block, ev_last, ev_frame, ev_half, ev_sync_lost} = m;
    if (want) expect_irq(cyc + 1, tag);
    @(negedge clk);
    {ev_block, ev_last, ev_frame, ev_half, ev_sync_lost} = '0;
  endtask

  task automatic rd(input logic a, output logic [5:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr_mask(input logic [5:0] v);
    bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic expect_status(input logic [5:0] v, input string tag);
    logic [5:0] d;
    rd(1'b1, d);
    check(d == v, tag, int'(d), int'(v));
  endtask

  task automatic hold_req(input logic [3:0] p, input int n);
    port_req = port_req | p;
    repeat (n) @(negedge clk);
    port_req = port_req & ~p;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [5:0] d;
    rst_n = 1'b0;
    {ev_block, ev_last, ev_frame, ev_half, ev_sync_lost} = '0;
    port_req = '0; port_gnt = '0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R9 reset state
    check(irq == 1'b0, "R9 irq after reset", int'(irq), 0);
    rd(1'b0, d); check(d == 6'd0, "R9 mask after reset", int'(d), 0);
    expect_status(6'd0, "R9 status after reset");

    // R8 mask write/readback: sync lost + frame
    wr_mask(6'b000101);
    rd(1'b0, d); check(d == 6'b000101, "R8 mask readback", int'(d), 5);

    // R2 enabled event
    pulse(5'b00001, 1'b1, "R2 sync lost irq");
    repeat (3) @(negedge clk);
    expect_status(6'b000001, "R4 status holds sync lost");
    expect_status(6'b000000, "R4 status cleared by read");

    // R3 masked event, R1 still recorded
    pulse(5'b00010, 1'b0, "R3");
    repeat (3) @(negedge clk);
    expect_status(6'b000010, "R1 masked half frame recorded");

    // two events on one edge, one enabled
    pulse(5'b01100, 1'b1, "R2 frame+last irq");
    repeat (2) @(negedge clk);
    expect_status(6'b001100, "R1 frame+last recorded");

    // R10 back-to-back pulses
    pulse(5'b00100, 1'b1, "R10 first pulse");
    pulse(5'b00100, 1'b1, "R10 second pulse");
    repeat (3) @(negedge clk);
    expect_status(6'b000100, "R4 frame status");

    // R5 event on the same edge as a status read
    ev_block = 1'b1; bus_rd = 1'b1; bus_addr = 1'b1;
    #1 d = bus_rdata;
    check(d == 6'd0, "R5 read value before event", int'(d), 0);
    @(negedge clk);
    ev_block = 1'b0; bus_rd = 1'b0;
    expect_status(6'b010000, "R5 block kept after same-edge read");

    // R8 unmasking a pending event
    pulse(5'b01000, 1'b0, "R3");
    repeat (2) @(negedge clk);
    expect_irq(cyc + 1, "R8 unmask pending last");
    wr_mask(6'b001101);
    repeat (3) @(negedge clk);
    expect_status(6'b001000, "R8 last still pending");

    // R6 stall time-out on port 2, R7 single pulse while held
    wr_mask(6'b100101);
    expect_irq(cyc + 256, "R6 port2 time-out irq");
    hold_req(4'b0100, 300);
    repeat (2) @(negedge clk);
    expect_status(6'b100000, "R6 time-out status");

    // R7 grant clears the count
    port_req[0] = 1'b1;
    repeat (200) @(negedge clk);
    port_gnt[0] = 1'b1; @(negedge clk); port_gnt[0] = 1'b0;
    repeat (200) @(negedge clk);
    port_req[0] = 1'b0;
    repeat (2) @(negedge clk);
    expect_status(6'b000000, "R7 grant restarts count");

    // R7 withdrawal at 254 cycles
    hold_req(4'b1000, 254);
    @(negedge clk);
    hold_req(4'b1000, 254);
    repeat (2) @(negedge clk);
    expect_status(6'b000000, "R7 withdraw at 254 no time-out");

    // R7 two ports together give one event
    expect_irq(cyc + 256, "R7 merged time-out irq");
    hold_req(4'b1010, 260);
    repeat (2) @(negedge clk);
    expect_status(6'b100000, "R7 merged time-out status");

    repeat (5) @(negedge clk);
    check(exp_cyc.size() == 0, "R2 all expected pulses seen", exp_cyc.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule